// File: doc/BRIEF.md
# Berger-Coded Output Checker

This block watches the output word of a programmable logic array whose result travels with a Berger check field. It rebuilds the check field from the information bits, which is the number of zero bits written in binary. It then tests the rebuilt field against the received field without a plain equality comparator. Each rebuilt bit is paired with the inverse of the matching received bit to form a dual-rail signal, and the pairs are reduced by a balanced tree of self-checking two-rail cells to one output pair.

A complementary output pair means the word and its field agree. An equal pair (00 or 11) means a mismatch was found, or a fault has occurred inside the checker. The final pair and a single error flag are registered, so the verdict for the inputs present at a clock edge appears just after that edge.

Top module: `bergerChecker`

## Requirements
- R1: The check field is `CW = ceil(log2(W+1))` bits wide (4 for W = 8) and is the binary count of zero bits in `infoWord`, with bit 0 as the LSB. For example, the word 01101011 gives 0011.
- R2: Outputs are registered. The verdict for the inputs sampled at a rising edge of `clk` appears after that edge, and input changes between edges do not reach the outputs.
- R3: When `checkIn` equals the count from R1, then after the next edge `pairF != pairG` and `errOut` = 0.
- R4: When `checkIn` differs from the count from R1, then after the next edge `pairF == pairG` and `errOut` = 1.
- R5: Every single-bit flip of an 8-bit information word, sent with the field of the unflipped word, is flagged (`errOut` = 1).
- R6: Every single-bit flip of a correct check field is flagged (`errOut` = 1).
- R7: The boundary words are handled correctly. All ones needs field 0 and all zeros needs field W; each is clean with that field and is flagged with any other field.
- R8: While `rstN` is low, the outputs take `pairF` = 0, `pairG` = 1 and `errOut` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| infoWord | input | W | Information bits from the array |
| checkIn | input | CW | Received check field (zero count, binary) |
| pairF | output | 1 | First rail of the checker output pair |
| pairG | output | 1 | Second rail of the checker output pair |
| errOut | output | 1 | High when the output pair is non-complementary |

## Verification
A wrong zero count, a swapped rail or a broken tree cell shows at the ports one edge after the offending inputs are applied. It appears as an equal output pair on a word that should pass, or as a complementary pair on a word that should fail. The sweep tries all 256 words with their correct field. It also tries every single flip of each word and of each field. As a result, any count error for any weight and any rail that fails to carry a mismatch is exposed on the first vector that touches it.

// File: rtl/bergerPkg.sv
package bergerPkg;

  // Dual-rail signal: a valid code is f != g
  typedef struct packed {
    logic f;
    logic g;
  } railPair_t;

  // Width needed to hold a zero count of 0..w
  function automatic int chkWidth(input int w);
    return $clog2(w + 1);
  endfunction

endpackage

// File: rtl/zeroCountGen.sv
module zeroCountGen #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic [W-1:0]  word,
  output logic [CW-1:0] zeroCount
);

  always_comb begin
    zeroCount = '0;
    for (int i = 0; i < W; i++) begin
      zeroCount = zeroCount + CW'(~word[i]);
    end
  end

endmodule

// File: rtl/twoRailCell.sv
module twoRailCell
  import bergerPkg::*;
(
  input  railPair_t a,
  input  railPair_t b,
  output railPair_t y
);

  // Complementary inputs give complementary output; any 00/11 input gives equal rails
  assign y.f = (a.f & b.f) | (a.g & b.g);
  assign y.g = (a.f & b.g) | (a.g & b.f);

endmodule

// File: rtl/twoRailTree.sv
module twoRailTree
  import bergerPkg::*;
#(
  parameter int N = 4
) (
  input  railPair_t [N-1:0] leaves,
  output railPair_t         root
);

  localparam int LVL = (N > 1) ? $clog2(N) : 0;
  localparam int P   = 1 << LVL;
  localparam int NODES = 2 * P - 1;

  railPair_t node [NODES];

  // Heap layout: leaves at P-1 .. 2P-2, padding slots hold a fixed valid code
  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node[P - 1 + i] = leaves[i];
    end else begin : g_pad
      assign node[P - 1 + i] = '{f: 1'b1, g: 1'b0};
    end
  end

  for (genvar k = 0; k < P - 1; k++) begin : g_cell
    twoRailCell u_cell (
      .a(node[2 * k + 1]),
      .b(node[2 * k + 2]),
      .y(node[k])
    );
  end

  assign root = node[0];

endmodule

// File: rtl/bergerChecker.sv
module bergerChecker
  import bergerPkg::*;
#(
  parameter  int W  = 8,
  localparam int CW = chkWidth(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  infoWord,
  input  logic [CW-1:0] checkIn,
  output logic          pairF,
  output logic          pairG,
  output logic          errOut
);

  logic [CW-1:0]        genCheck;
  railPair_t [CW-1:0]   leaves;
  railPair_t            root;

  zeroCountGen #(.W(W), .CW(CW)) u_count (
    .word     (infoWord),
    .zeroCount(genCheck)
  );

  // Regenerated bit on one rail, inverted received bit on the other
  for (genvar i = 0; i < CW; i++) begin : g_pair
    assign leaves[i] = '{f: genCheck[i], g: ~checkIn[i]};
  end

  twoRailTree #(.N(CW)) u_tree (
    .leaves(leaves),
    .root  (root)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairF  <= 1'b0;
      pairG  <= 1'b1;
      errOut <= 1'b0;
    end else begin
      pairF  <= root.f;
      pairG  <= root.g;
      errOut <= (root.f == root.g);
    end
  end

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(genCheck) <= W);

  // R3
  match_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (checkIn == genCheck) |=> (!errOut && (pairF != pairG)));

  // R4
  mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (checkIn != genCheck) |=> (errOut && (pairF == pairG)));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!pairF && pairG && !errOut));

endmodule

// File: tb/test_bergerChecker.sv
module test_bergerChecker;

  localparam int W = 8;
  localparam int CW = 4;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  infoWord = '0;
  logic [CW-1:0] checkIn = '0;
  logic          pairF, pairG, errOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bergerChecker #(.W(W)) i_bergerChecker (
    .clk     (clk),
    .rstN    (rstN),
    .infoWord(infoWord),
    .checkIn (checkIn),
    .pairF   (pairF),
    .pairG   (pairG),
    .errOut  (errOut)
  );

  function automatic logic [CW-1:0] zerosOf(input logic [W-1:0] w);
    int n = 0;
    for (int i = 0; i < W; i++) if (w[i] == 1'b0) n++;
    return CW'(n);
  endfunction

  task automatic expectBit(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, check at the next falling edge
  task automatic applyCheck(input string tag, input logic [W-1:0] w,
                            input logic [CW-1:0] c, input logic expErr);
    infoWord = w;
    checkIn  = c;
    @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (errOut !== expErr || ((pairF == pairG) !== expErr)) begin
      testsFailed++;
      $display("FAIL %s: word %b field %b actual err=%b f=%b g=%b expected err=%b",
               tag, w, c, errOut, pairF, pairG, expErr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    expectBit("R8 pairF", pairF, 1'b0);
    expectBit("R8 pairG", pairG, 1'b1);
    expectBit("R8 errOut", errOut, 1'b0);
    rstN = 1'b1;

    // R1: example word from the requirement
    expectBit("R1 example count", zerosOf(8'b01101011) == 4'b0011, 1'b1);
    applyCheck("R1 example", 8'b01101011, 4'b0011, 1'b0);

    // R7: boundary words
    applyCheck("R7 all ones clean", 8'hFF, 4'd0, 1'b0);
    applyCheck("R7 all zeros clean", 8'h00, 4'd8, 1'b0);
    applyCheck("R7 all ones bad", 8'hFF, 4'd1, 1'b1);
    applyCheck("R7 all zeros bad", 8'h00, 4'd7, 1'b1);
    applyCheck("R7 all zeros field 0", 8'h00, 4'd0, 1'b1);

    // R2: inputs changed between edges do not reach the outputs
    applyCheck("R2 setup", 8'hA5, zerosOf(8'hA5), 1'b0);
    checkIn = ~zerosOf(8'hA5);
    #1;
    expectBit("R2 hold before edge", errOut, 1'b0);
    @(posedge clk);
    @(negedge clk);
    expectBit("R2 after edge", errOut, 1'b1);

    for (int w = 0; w < 256; w++) begin
      logic [CW-1:0] good;
      good = zerosOf(W'(w));
      // R3: correct field passes
      applyCheck("R3 match", W'(w), good, 1'b0);
      // R5: each word bit flipped
      for (int b = 0; b < W; b++) begin
        applyCheck("R5 word flip", W'(w) ^ (W'(1) << b), good, 1'b1);
      end
      // R6 / R4: each field bit flipped
      for (int b = 0; b < CW; b++) begin
        applyCheck("R6 R4 field flip", W'(w), good ^ (CW'(1) << b), 1'b1);
      end
    end

    // R8: reset mid-run returns to the reset state
    infoWord = 8'h0F;
    checkIn  = 4'd0;
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    expectBit("R8 rerun err", errOut, 1'b0);
    expectBit("R8 rerun pairG", pairG, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule